// File: doc/BRIEF.md
# Serviced Watchdog Timer with Early-Warning Interrupt

This block is a watchdog peripheral. Software reaches it through five 16-bit registers on a simple synchronous register bus. A down-counter measures the watchdog period in half-second steps. The steps are cut from the slow timebase clock by a parameterised divider. Software keeps the system alive by writing a two-word key pair to the service register. When the counter runs out, the block asks for a reset. A control bit picks the target: either the chip's internal reset, or only the active-low external reset pin.

Software can also reset the chip or drive the external pin directly, through two active-low control bits. A status bit records whether the last reset came from a timeout. An interrupt can be set to fire a chosen number of half-second steps before expiry, and software clears it by writing 1 to its flag. A separate power-down counter starts at reset. When it runs out, it drops the interrupt line for one clock, unless software switched it off first.

The block runs entirely in the timebase clock domain and on the power-on reset. Its own reset outputs do not reset it, so the cause bit survives them.

Top module: `wdog_top`

## Requirements
- R1: After power-on reset, the registers read as follows: control (offset 0x0) 0x0030, service (0x2) 0x0000, status (0x4) 0x0000, interrupt control (0x6) 0x0000, misc (0x8) 0x0001. The outputs are chipRstReq=0, extRstN=1 and irqN=1.
- R2: Control bits 15:8 hold a value N. Once the timer is enabled or reloaded, it expires after (N+1) half-second steps of TICK_DIV clocks each. After expiry it reloads itself and keeps counting.
- R3: The counter reloads only when a service write of 0x5555 is followed directly by a service write of 0xAAAA. Any other service word in between, or the reverse order, does not reload it.
- R4: Control bit 2 enables the timer, and the first write of 1 also loads the counter. A later write of 0 does not stop the timer, and bit 2 keeps reading 1.
- R5: While control bit 0 is 1 and lowPower is high, counting is frozen. Bit 0 can be written only once after reset, and later writes leave it unchanged. With bit 0 clear, lowPower has no effect.
- R6: Control bit 3 selects the action on expiry. With 0, chipRstReq goes high for RST_PULSE clocks. With 1, extRstN goes low for RST_PULSE clocks and chipRstReq stays low.
- R7: Writing 0 to control bit 4 raises chipRstReq for RST_PULSE clocks from that write's edge, and bit 4 always reads back 1. Control bit 5 is a level: while it holds 0, extRstN is low.
- R8: Status bit 1 is set by a timeout and cleared by a software reset through control bit 4.
- R9: Interrupt-control bit 15 enables the early warning, and bits 7:0 give its lead L in half-second steps. Flag bit 14 sets when the counter reaches L, that is (N+1-L) steps after a load, and irqN is low while the flag is set. Writing 1 to bit 14 clears the flag. With bit 15 clear, the flag never sets.
- R10: The power-down counter fires PD_TICKS steps after reset and drives irqN low for exactly one clock, only once. Writing 0 to misc bit 0 stops it for good, and the bit then reads 0.
- R11: Writing a new timeout value while the timer runs does not restart the count. The new value applies from the next reload, whether that reload comes from expiry or from the service pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rstN | input | 1 | Power-on reset, active low |
| busSel | input | 1 | Register access strobe |
| busWr | input | 1 | Write when high, read when low |
| busAddr | input | 4 | Byte offset of the register |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, combinational from busAddr |
| lowPower | input | 1 | Low-power mode indication |
| chipRstReq | output | 1 | Internal chip reset request, active high |
| extRstN | output | 1 | External reset pin, active low |
| irqN | output | 1 | Interrupt line, active low |

## Verification
The bench looks for key-sequence mistakes: reverse order, a stray word between the keys, and an enable write that fails to load the counter. A design that got these wrong would reload early or never, and the expiry cycle would move. It measures expiry, early-warning and power-down events to the exact clock. An off-by-one step in N+1, a missed freeze, or a timeout change that restarts the count all show up as a shifted event cycle. It also checks the write-once enable and suspend bits and the routing of resets between the two outputs. A design that mis-routes a reset would fire the wrong pin or keep a pulse for the wrong number of clocks. Last, it checks the cause bit across both kinds of reset.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 4;
  localparam int TO_W   = 8;
  localparam int CNT_W  = TO_W + 1;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] A_SVC  = 4'h2;
  localparam logic [ADDR_W-1:0] A_STAT = 4'h4;
  localparam logic [ADDR_W-1:0] A_INT  = 4'h6;
  localparam logic [ADDR_W-1:0] A_MISC = 4'h8;

  localparam logic [REG_W-1:0] KEY_ARM  = 16'h5555;
  localparam logic [REG_W-1:0] KEY_FIRE = 16'hAAAA;

  // control -> datapath strobes and settings
  typedef struct packed {
    logic            reload;
    logic            enabled;
    logic            suspend;
    logic            preEn;
    logic            pdRun;
    logic [TO_W-1:0] timeoutVal;
    logic [TO_W-1:0] leadVal;
  } dpCmd_t;

  // datapath -> control events
  typedef struct packed {
    logic expire;
    logic preHit;
    logic pdExpire;
  } dpEvt_t;
endpackage

// File: rtl/wdog_stretch.sv
module wdog_stretch #(
  parameter int LEN = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic trig,
  output logic active
);
  localparam int W = $clog2(LEN + 1);
  localparam logic [W-1:0] LOAD = W'(LEN);

  logic [W-1:0] holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                holdCnt <= '0;
    else if (trig)            holdCnt <= LOAD;
    else if (holdCnt != '0)   holdCnt <= holdCnt - W'(1);
  end

  assign active = (holdCnt != '0);
endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int TICK_DIV = 16384,
  parameter int PD_TICKS = 32
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   lowPower,
  input  dpCmd_t cmd,
  output dpEvt_t evt
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
  localparam int PD_W = $clog2(PD_TICKS + 1);
  localparam logic [PD_W-1:0] PD_LAST = PD_W'(PD_TICKS - 1);

  logic [PRE_W-1:0] preCnt;
  logic             tick;
  logic [CNT_W-1:0] toCnt, reloadVal, toDec;
  logic             run;
  logic [PD_W-1:0]  pdCnt;
  logic             pdDone;

  // half-second step generator, restarted by every explicit load
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              preCnt <= '0;
    else if (cmd.reload)    preCnt <= '0;
    else if (preCnt == PRE_LAST) preCnt <= '0;
    else                    preCnt <= preCnt + PRE_W'(1);
  end

  assign tick      = (preCnt == PRE_LAST);
  assign run       = cmd.enabled & ~(cmd.suspend & lowPower);
  assign reloadVal = {1'b0, cmd.timeoutVal} + CNT_W'(1);
  assign toDec     = toCnt - CNT_W'(1);

  always_comb begin
    evt.expire   = tick & run & ~cmd.reload & (toCnt == CNT_W'(1));
    evt.preHit   = tick & run & ~cmd.reload & cmd.preEn & (toCnt != '0) &
                   (toDec == {1'b0, cmd.leadVal});
    evt.pdExpire = tick & cmd.pdRun & ~pdDone & (pdCnt == PD_LAST);
  end

  // timeout counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  toCnt <= '0;
    else if (cmd.reload)        toCnt <= reloadVal;
    else if (tick && run) begin
      if (toCnt == CNT_W'(1))   toCnt <= reloadVal;
      else if (toCnt != '0)     toCnt <= toDec;
    end
  end

  // power-down counter, one shot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pdCnt  <= '0;
      pdDone <= 1'b0;
    end else if (tick && cmd.pdRun && !pdDone) begin
      if (pdCnt == PD_LAST) pdDone <= 1'b1;
      else                  pdCnt  <= pdCnt + PD_W'(1);
    end
  end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int RST_PULSE = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  output logic [REG_W-1:0]  busRdata,
  input  dpEvt_t            evt,
  output dpCmd_t            cmd,
  output logic              chipRstReq,
  output logic              extRstN,
  output logic              irqN
);
  localparam int N_RST = 2;   // 0: internal, 1: external

  logic wrCtrl, wrSvc, wrInt, wrMisc;
  logic [TO_W-1:0] toVal, leadVal;
  logic actExt, extLevelN, enBit, suspBit, suspLocked;
  logic armed, causeTo, irqEn, irqFlag, pdEn, pdPulse;
  logic swReset, svcFire, enLoad;
  logic [N_RST-1:0] rstTrig, rstActive;

  assign wrCtrl = busSel & busWr & (busAddr == A_CTRL);
  assign wrSvc  = busSel & busWr & (busAddr == A_SVC);
  assign wrInt  = busSel & busWr & (busAddr == A_INT);
  assign wrMisc = busSel & busWr & (busAddr == A_MISC);

  assign swReset = wrCtrl & ~busWdata[4];
  assign svcFire = wrSvc & armed & (busWdata == KEY_FIRE);
  assign enLoad  = wrCtrl & busWdata[2] & ~enBit;

  // control register with write-once fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toVal      <= '0;
      actExt     <= 1'b0;
      extLevelN  <= 1'b1;
      enBit      <= 1'b0;
      suspBit    <= 1'b0;
      suspLocked <= 1'b0;
    end else if (wrCtrl) begin
      toVal     <= busWdata[15:8];
      actExt    <= busWdata[3];
      extLevelN <= busWdata[5];
      if (busWdata[2]) enBit <= 1'b1;
      if (!suspLocked) begin
        suspBit    <= busWdata[0];
        suspLocked <= 1'b1;
      end
    end
  end

  // key sequence tracker
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      armed <= 1'b0;
    else if (wrSvc) armed <= (busWdata == KEY_ARM);
  end

  // reset cause
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           causeTo <= 1'b0;
    else if (evt.expire) causeTo <= 1'b1;
    else if (swReset)    causeTo <= 1'b0;
  end

  // early-warning interrupt
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEn   <= 1'b0;
      irqFlag <= 1'b0;
      leadVal <= '0;
    end else begin
      if (wrInt) begin
        irqEn   <= busWdata[15];
        leadVal <= busWdata[7:0];
      end
      if (evt.preHit)                 irqFlag <= 1'b1;
      else if (wrInt && busWdata[14]) irqFlag <= 1'b0;
    end
  end

  // power-down counter control
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pdEn    <= 1'b1;
      pdPulse <= 1'b0;
    end else begin
      if (wrMisc && !busWdata[0]) pdEn <= 1'b0;
      pdPulse <= evt.pdExpire;
    end
  end

  // reset pulse generation
  assign rstTrig[0] = swReset | (evt.expire & ~actExt);
  assign rstTrig[1] = evt.expire & actExt;

  for (genvar g = 0; g < N_RST; g++) begin : g_rst
    wdog_stretch #(.LEN(RST_PULSE)) u_stretch (
      .clk    (clk),
      .rstN   (rstN),
      .trig   (rstTrig[g]),
      .active (rstActive[g])
    );
  end

  assign chipRstReq = rstActive[0];
  assign extRstN    = ~rstActive[1] & extLevelN;
  assign irqN       = ~(irqFlag | pdPulse);

  always_comb begin
    cmd.reload     = enLoad | svcFire;
    cmd.enabled    = enBit;
    cmd.suspend    = suspBit;
    cmd.preEn      = irqEn;
    cmd.pdRun      = pdEn;
    cmd.timeoutVal = wrCtrl ? busWdata[15:8] : toVal;
    cmd.leadVal    = leadVal;
  end

  always_comb begin
    case (busAddr)
      A_CTRL:  busRdata = {toVal, 2'b00, extLevelN, 1'b1, actExt, enBit, 1'b0, suspBit};
      A_STAT:  busRdata = {14'b0, causeTo, 1'b0};
      A_INT:   busRdata = {irqEn, irqFlag, 6'b0, leadVal};
      A_MISC:  busRdata = {15'b0, pdEn};
      default: busRdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int TICK_DIV  = 16384,
  parameter int PD_TICKS  = 32,
  parameter int RST_PULSE = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  output logic [REG_W-1:0]  busRdata,
  input  logic              lowPower,
  output logic              chipRstReq,
  output logic              extRstN,
  output logic              irqN
);
  dpCmd_t cmd;
  dpEvt_t evt;

  wdog_ctrl #(.RST_PULSE(RST_PULSE)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busSel     (busSel),
    .busWr      (busWr),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .evt        (evt),
    .cmd        (cmd),
    .chipRstReq (chipRstReq),
    .extRstN    (extRstN),
    .irqN       (irqN)
  );

  wdog_datapath #(.TICK_DIV(TICK_DIV), .PD_TICKS(PD_TICKS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .lowPower (lowPower),
    .cmd      (cmd),
    .evt      (evt)
  );
endmodule

// File: rtl/wdog_checks.sv
module wdog_checks
  import wdog_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [REG_W-1:0]  busWdata,
  input logic              lowPower,
  input dpCmd_t            cmd,
  input dpEvt_t            evt,
  input logic              chipRstReq,
  input logic              extRstN,
  input logic              irqN
);
  logic ctrlWr, keyWr;
  assign ctrlWr = busSel && busWr && (busAddr == A_CTRL);
  assign keyWr  = busSel && busWr && (busAddr == A_SVC) && (busWdata == KEY_FIRE);

  p_reload_source_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.reload |-> (ctrlWr || keyWr));

  p_enable_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    $past(cmd.enabled) |-> cmd.enabled);

  p_freeze_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.suspend && lowPower) |-> (!evt.expire && !evt.preHit));

  p_int_cause_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chipRstReq) |-> $past(evt.expire || (ctrlWr && !busWdata[4])));

  p_ext_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(extRstN) |-> $past(evt.expire || ctrlWr));

  p_pre_irq_r9: assert property (@(posedge clk) disable iff (!rstN)
    evt.preHit |=> !irqN);

  p_pd_irq_r10: assert property (@(posedge clk) disable iff (!rstN)
    evt.pdExpire |=> !irqN);
endmodule

bind wdog_top wdog_checks u_checks (
  .clk        (clk),
  .rstN       (rstN),
  .busSel     (busSel),
  .busWr      (busWr),
  .busAddr    (busAddr),
  .busWdata   (busWdata),
  .lowPower   (lowPower),
  .cmd        (cmd),
  .evt        (evt),
  .chipRstReq (chipRstReq),
  .extRstN    (extRstN),
  .irqN       (irqN)
);

// File: tb/tb_wdog_top.sv
`timescale 1ns/1ps
module tb_wdog_top;
  localparam int DIV   = 4;
  localparam int PD    = 3;
  localparam int PULSE = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWr = 1'b0, lowPower = 1'b0;
  logic [3:0] busAddr = '0;
  logic [15:0] busWdata = '0, busRdata;
  logic chipRstReq, extRstN, irqN;

  int cyc = 0, lastWr = 0, relCyc = 0;
  int nChk = 0, nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_top #(.TICK_DIV(DIV), .PD_TICKS(PD), .RST_PULSE(PULSE)) dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .lowPower(lowPower),
    .chipRstReq(chipRstReq), .extRstN(extRstN), .irqN(irqN)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
    end
  endtask

  task automatic doReset(input bit killPd);
    rstN = 1'b0; busSel = 1'b0; busWr = 1'b0; lowPower = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    relCyc = cyc;
    if (killPd) wr(4'h8, 16'h0000);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    #1;
    busSel = 1'b0; busWr = 1'b0;
    lastWr = cyc;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    busAddr = a; busSel = 1'b1; busWr = 1'b0;
    #1;
    d = busRdata;
    busSel = 1'b0;
  endtask

  function automatic bit sigOn(input int sel);
    case (sel)
      0: return chipRstReq;
      1: return !extRstN;
      default: return !irqN;
    endcase
  endfunction

  // returns cycle stamp of the first observation, or -1
  task automatic waitSig(input int sel, input int maxc, output int k);
    k = -1;
    for (int i = 0; i < maxc; i++) begin
      if (sigOn(sel)) begin k = cyc; break; end
      @(posedge clk); #1;
    end
  endtask

  task automatic measHigh(input int sel, output int n);
    n = 0;
    while (sigOn(sel) && n < 50) begin n++; @(posedge clk); #1; end
  endtask

  task automatic t_reset_state;
    logic [15:0] d;
    doReset(1'b0);
    check("R1", chipRstReq, 0, "chipRstReq after reset");
    check("R1", extRstN, 1, "extRstN after reset");
    check("R1", irqN, 1, "irqN after reset");
    rd(4'h0, d); check("R1", d, 16'h0030, "control reset value");
    rd(4'h2, d); check("R1", d, 16'h0000, "service reset value");
    rd(4'h4, d); check("R1", d, 16'h0000, "status reset value");
    rd(4'h6, d); check("R1", d, 16'h0000, "interrupt reset value");
    rd(4'h8, d); check("R1", d, 16'h0001, "misc reset value");
  endtask

  task automatic t_timeout_internal;
    int k, n, e0; logic [15:0] d;
    doReset(1'b1);
    wr(4'h0, 16'h0334); e0 = lastWr;
    waitSig(0, 100, k);
    check("R2", k - e0, 16, "internal expiry cycle N=3");
    check("R6", extRstN, 1, "extRstN during internal reset");
    measHigh(0, n);
    check("R6", n, PULSE, "internal pulse length");
    rd(4'h4, d); check("R8", d, 16'h0002, "cause after timeout");
  endtask

  task automatic t_timeout_external;
    int k, n, e0;
    doReset(1'b1);
    wr(4'h0, 16'h013C); e0 = lastWr;
    waitSig(1, 100, k);
    check("R6", k - e0, 8, "external expiry cycle N=1");
    check("R6", chipRstReq, 0, "chipRstReq during external action");
    measHigh(1, n);
    check("R6", n, PULSE, "external pulse length");
  endtask

  task automatic t_service;
    int k, e0;
    doReset(1'b1);
    wr(4'h0, 16'h0334);
    repeat (6) @(posedge clk);
    wr(4'h2, 16'h5555);
    wr(4'h2, 16'hAAAA); e0 = lastWr;
    waitSig(0, 100, k);
    check("R3", k - e0, 16, "expiry after key pair reload");
    doReset(1'b1);
    wr(4'h0, 16'h0334); e0 = lastWr;
    wr(4'h2, 16'hAAAA);
    wr(4'h2, 16'h5555);
    wr(4'h2, 16'h1234);
    wr(4'h2, 16'hAAAA);
    waitSig(0, 100, k);
    check("R3", k - e0, 16, "no reload on bad key order");
  endtask

  task automatic t_sticky;
    int k, e0; logic [15:0] d;
    doReset(1'b1);
    wr(4'h0, 16'h0334); e0 = lastWr;
    wr(4'h0, 16'h0330);
    rd(4'h0, d); check("R4", d[2], 1, "enable bit after clear attempt");
    waitSig(0, 100, k);
    check("R4", k - e0, 16, "timer keeps running after clear attempt");
  endtask

  task automatic t_suspend;
    int k, e0; logic [15:0] d;
    doReset(1'b1);
    wr(4'h0, 16'h0335); e0 = lastWr;
    wr(4'h0, 16'h0334);
    rd(4'h0, d); check("R5", d[0], 1, "suspend bit write-once");
    @(negedge clk); lowPower = 1'b1;
    repeat (20) @(negedge clk);
    lowPower = 1'b0;
    waitSig(0, 100, k);
    check("R5", k - e0, 36, "expiry delayed by frozen 20 clocks");
    doReset(1'b1);
    lowPower = 1'b1;
    wr(4'h0, 16'h0334); e0 = lastWr;
    waitSig(0, 100, k);
    check("R5", k - e0, 16, "lowPower ignored without suspend bit");
    lowPower = 1'b0;
  endtask

  task automatic t_software;
    int k, n; logic [15:0] d;
    doReset(1'b1);
    wr(4'h0, 16'h0334);
    waitSig(0, 100, k);
    measHigh(0, n);
    wr(4'h0, 16'h2834);
    wr(4'h2, 16'h5555);
    wr(4'h2, 16'hAAAA);
    rd(4'h4, d); check("R8", d, 16'h0002, "cause set before software reset");
    wr(4'h0, 16'h2824);
    check("R7", chipRstReq, 1, "software reset asserts at write edge");
    measHigh(0, n);
    check("R7", n, PULSE, "software reset pulse length");
    rd(4'h4, d); check("R8", d, 16'h0000, "cause cleared by software reset");
    rd(4'h0, d); check("R7", d[4], 1, "bit4 reads back 1");
    wr(4'h0, 16'h2814);
    check("R7", extRstN, 0, "bit5 low drives extRstN low");
    repeat (3) @(posedge clk); #1;
    check("R7", extRstN, 0, "extRstN held while bit5 low");
    wr(4'h0, 16'h2834);
    check("R7", extRstN, 1, "bit5 high releases extRstN");
  endtask

  task automatic t_pretimeout;
    int k, e0; logic [15:0] d;
    doReset(1'b1);
    wr(4'h6, 16'h8002);
    wr(4'h0, 16'h0334); e0 = lastWr;
    waitSig(2, 100, k);
    check("R9", k - e0, 8, "early warning cycle L=2");
    rd(4'h6, d); check("R9", d, 16'hC002, "flag visible");
    wr(4'h6, 16'hC002);
    check("R9", irqN, 1, "flag cleared by write 1");
    waitSig(0, 100, k);
    check("R9", k - e0, 16, "expiry unchanged by warning");
    doReset(1'b1);
    wr(4'h6, 16'h0002);
    wr(4'h0, 16'h0334);
    waitSig(2, 17, k);
    check("R9", k, -1, "no warning with enable clear");
  endtask

  task automatic t_powerdown;
    int k, n; logic [15:0] d;
    doReset(1'b0);
    waitSig(2, 100, k);
    check("R10", k - relCyc, PD*DIV, "power-down pulse cycle");
    measHigh(2, n);
    check("R10", n, 1, "power-down pulse width");
    waitSig(2, 60, k);
    check("R10", k, -1, "power-down fires once");
    doReset(1'b1);
    waitSig(2, 60, k);
    check("R10", k, -1, "disabled power-down stays quiet");
    rd(4'h8, d); check("R10", d, 16'h0000, "misc reads disabled");
  endtask

  task automatic t_new_timeout;
    int k, n, e0;
    doReset(1'b1);
    wr(4'h0, 16'h0334); e0 = lastWr;
    wr(4'h0, 16'h0134);
    waitSig(0, 100, k);
    check("R11", k - e0, 16, "running count not restarted");
    measHigh(0, n);
    waitSig(0, 100, k);
    check("R11", k - e0, 24, "new value used after auto reload");
  endtask

  initial begin
    t_reset_state();
    t_timeout_internal();
    t_timeout_external();
    t_service();
    t_sticky();
    t_suspend();
    t_software();
    t_pretimeout();
    t_powerdown();
    t_new_timeout();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end
endmodule